// File: doc/BRIEF.md
# Aligned Multi-Ratio Clock Divider

This block takes one fast base clock and derives a synchronous family of four slower clocks from it. Each derived clock appears twice: as a registered square-wave level and as a one-base-cycle enable pulse marking that clock's rising edge. Two ratios are fixed. A bus clock can run either at the rate of its half-rate parent or at half of that. A debug clock runs at one half or one quarter of its quarter-rate parent. All four are generated from a single shared phase counter, so their rising edges line up every time the slowest clock rises.

Software changes ratios and gates through a small write port. A write to the ratio register is held as a pending value while a busy flag is raised. Hardware then loads the pending value on the last base cycle before the slowest clock's next rising edge. At that cycle every output is low, so the change produces neither a runt pulse nor a glitch. Each output has its own software gate, applied at that output's own period boundary. A hardware run input stops and restarts the whole group together, again only at the alignment point.

Top module: `aligned_clk_divider`

## Requirements
- R1: After reset the phase counter is zero, every clk_o and en_o bit is low, busy_o is low, all software gates are open, and both select bits are 0 (the smallest divide). All outputs stay low until the first alignment point after reset.
- R2: Output 0 divides the base clock by 2 and output 1 divides it by 4. Each has a 50% duty cycle, and its en_o bit is high for exactly one base cycle per period, in the cycle where its clock level rises.
- R3: Output 2 follows ratio-register bit 0 (address 0): 0 gives base/2, equal to its half-rate parent; 1 gives base/4.
- R4: Output 3 follows ratio-register bit 1 (address 0): 0 gives its quarter-rate parent divided by 2 (base/8); 1 gives that parent divided by 4 (base/16).
- R5: A new ratio setting is loaded only on the base cycle in which the phase counter holds its all-ones value, one cycle before the slowest output rises. Whenever output 3 rises, every running output rises in the same cycle.
- R6: A write to address 0 raises busy_o from the next cycle until the cycle in which the ratio loads. A further write while busy replaces the pending value, so the last write wins.
- R7: Address 1 bit i gates output i (1 = run). A change takes effect only at that output's own rising-edge boundary. A gated output holds clk_o and en_o low, the other outputs keep running, and a write to address 1 does not raise busy_o.
- R8: Every high phase and every low phase of every output lasts exactly half of its current period.
- R9: grp_run_i is sampled only at the alignment point. When it is sampled as 0, all group outputs stop low together. When it is sampled as 1 again, they all restart with a common rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast base clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 1 | 0 = ratio select, 1 = software gates |
| wr_data_i | input | 4 | Write data (ratio: bit 0 bus, bit 1 debug; gates: bit per output) |
| grp_run_i | input | 1 | Hardware group run request, applied at alignment |
| busy_o | output | 1 | Ratio change pending |
| clk_o | output | 4 | Registered derived clock levels |
| en_o | output | 4 | Rising-edge enable pulses, one per derived clock |

## Verification
The bench builds the block with its default exponents: fixed outputs at base/2 and base/4, a bus parent at base/2 and a debug parent at base/4. This gives a 16-cycle shared cycle. With that cycle length, every select combination can be measured as exact period and high-time counts within a few dozen base cycles. It also makes the alignment point reachable at a known count once the bench locks onto the falling edge of busy_o. That lock turns the busy duration and the last-write-wins replacement into exact cycle counts. The same setup covers the gate and group-stop windows, which are checked over whole slow periods.

// File: rtl/acd_pkg.sv
package acd_pkg;
    localparam int N_OUT    = 4;
    localparam int OUT_FAST = 0;
    localparam int OUT_SLOW = 1;
    localparam int OUT_BUS  = 2;
    localparam int OUT_DBG  = 3;

    localparam int SEL_BUS_BIT = 0;
    localparam int SEL_DBG_BIT = 1;

    typedef enum logic {
        REG_RATIO = 1'b0,
        REG_GATE  = 1'b1
    } acd_reg_e;

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/acd_phase_cnt.sv
module acd_phase_cnt #(
    parameter int CNT_W = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    output logic [CNT_W-1:0] cnt_o,
    output logic             align_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.cnt = st_q.cnt + CNT_W'(1);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign cnt_o   = st_q.cnt;
    assign align_o = &st_q.cnt;
endmodule

// File: rtl/acd_ctrl.sv
module acd_ctrl
    import acd_pkg::*;
#(
    parameter int               EXP_W          = 3,
    parameter int               FAST_EXP       = 1,
    parameter int               SLOW_EXP       = 2,
    parameter int               BUS_PARENT_EXP = 1,
    parameter int               DBG_PARENT_EXP = 2,
    parameter logic [N_OUT-1:0] GROUP_MASK     = '1
) (
    input  logic                        clk_i,
    input  logic                        rst_ni,
    input  logic                        wr_en_i,
    input  logic                        wr_addr_i,
    input  logic [N_OUT-1:0]            wr_data_i,
    input  logic                        align_i,
    input  logic                        grp_run_i,
    output logic                        busy_o,
    output logic [N_OUT-1:0][EXP_W-1:0] exp_o,
    output logic [N_OUT-1:0]            sw_en_o,
    output logic [N_OUT-1:0]            run_o
);
    typedef struct packed {
        logic [1:0]       sel_pend;
        logic [1:0]       sel_act;
        logic             busy;
        logic [N_OUT-1:0] sw_en;
        logic             grp_on;
        logic             live;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (align_i) begin
            st_d.live   = 1'b1;
            st_d.grp_on = grp_run_i;
            if (st_q.busy) begin
                st_d.sel_act = st_q.sel_pend;
                st_d.busy    = 1'b0;
            end
        end
        if (wr_en_i && (acd_reg_e'(wr_addr_i) == REG_RATIO)) begin
            st_d.sel_pend = wr_data_i[1:0];
            st_d.busy     = 1'b1;
        end
        if (wr_en_i && (acd_reg_e'(wr_addr_i) == REG_GATE)) begin
            st_d.sw_en = wr_data_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.sel_pend <= '0;
            st_q.sel_act  <= '0;
            st_q.busy     <= 1'b0;
            st_q.sw_en    <= '1;
            st_q.grp_on   <= 1'b0;
            st_q.live     <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        exp_o[OUT_FAST] = EXP_W'(FAST_EXP);
        exp_o[OUT_SLOW] = EXP_W'(SLOW_EXP);
        exp_o[OUT_BUS]  = EXP_W'(BUS_PARENT_EXP) + EXP_W'(st_q.sel_act[SEL_BUS_BIT]);
        exp_o[OUT_DBG]  = EXP_W'(DBG_PARENT_EXP + 1) + EXP_W'(st_q.sel_act[SEL_DBG_BIT]);
    end

    for (genvar g = 0; g < N_OUT; g++) begin : g_run
        if (GROUP_MASK[g]) begin : g_grp
            assign run_o[g] = st_q.grp_on;
        end else begin : g_free
            assign run_o[g] = st_q.live;
        end
    end

    assign busy_o  = st_q.busy;
    assign sw_en_o = st_q.sw_en;

    // R5: active ratios move only on the edge that ends the alignment cycle
    a_r5_load_at_align: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(st_q.sel_act) |-> $past(align_i));

    // R6: busy drops only when the pending value has just been applied
    a_r6_busy_ends_on_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(st_q.busy) |-> ($past(align_i) && (st_q.sel_act == $past(st_q.sel_pend))));

    // R9: the group run state changes only at the alignment point
    a_r9_group_at_align: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(st_q.grp_on) |-> $past(align_i));
endmodule

// File: rtl/acd_out_gen.sv
module acd_out_gen #(
    parameter int CNT_W = 4,
    parameter int EXP_W = 3
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [EXP_W-1:0] exp_i,
    input  logic             sw_en_i,
    input  logic             run_i,
    output logic             clk_o,
    output logic             en_o
);
    typedef struct packed {
        logic gate;
        logic clk;
        logic en;
    } out_st_t;

    out_st_t          st_d, st_q;
    logic [CNT_W:0]   one_sh;
    logic [CNT_W-1:0] mask;
    logic [CNT_W-1:0] phase;
    logic             at_last;
    logic             at_zero;
    logic             half_hi;
    logic             on;

    always_comb begin
        one_sh  = (CNT_W+1)'(1) << exp_i;
        mask    = CNT_W'(one_sh - (CNT_W+1)'(1));
        phase   = cnt_i & mask;
        at_last = (phase == mask);
        at_zero = (phase == '0);
        half_hi = |(phase & ~(mask >> 1));
        on      = st_q.gate & run_i;

        st_d      = st_q;
        st_d.gate = at_last ? sw_en_i : st_q.gate;
        st_d.clk  = on & ~half_hi;
        st_d.en   = on & at_zero;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.gate <= 1'b1;
            st_q.clk  <= 1'b0;
            st_q.en   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign clk_o = st_q.clk;
    assign en_o  = st_q.en;

    // R2: an enable pulse never lasts longer than one base cycle
    a_r2_en_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.en |=> !st_q.en);

    // R8: a clock level only rises together with its enable pulse
    a_r8_rise_with_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(st_q.clk) |-> st_q.en);
endmodule

// File: rtl/aligned_clk_divider.sv
module aligned_clk_divider
    import acd_pkg::*;
#(
    parameter int               FAST_EXP       = 1,
    parameter int               SLOW_EXP       = 2,
    parameter int               BUS_PARENT_EXP = 1,
    parameter int               DBG_PARENT_EXP = 2,
    parameter logic [N_OUT-1:0] GROUP_MASK     = '1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wr_en_i,
    input  logic             wr_addr_i,
    input  logic [N_OUT-1:0] wr_data_i,
    input  logic             grp_run_i,
    output logic             busy_o,
    output logic [N_OUT-1:0] clk_o,
    output logic [N_OUT-1:0] en_o
);
    localparam int CNT_W = max_int(max_int(FAST_EXP, SLOW_EXP),
                                   max_int(BUS_PARENT_EXP + 1, DBG_PARENT_EXP + 2));
    localparam int EXP_W = $clog2(CNT_W + 1);

    logic [CNT_W-1:0]            cnt;
    logic                        align;
    logic [N_OUT-1:0][EXP_W-1:0] exps;
    logic [N_OUT-1:0]            sw_en;
    logic [N_OUT-1:0]            run;

    acd_phase_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .cnt_o   (cnt),
        .align_o (align)
    );

    acd_ctrl #(
        .EXP_W          (EXP_W),
        .FAST_EXP       (FAST_EXP),
        .SLOW_EXP       (SLOW_EXP),
        .BUS_PARENT_EXP (BUS_PARENT_EXP),
        .DBG_PARENT_EXP (DBG_PARENT_EXP),
        .GROUP_MASK     (GROUP_MASK)
    ) u_ctrl (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .align_i   (align),
        .grp_run_i (grp_run_i),
        .busy_o    (busy_o),
        .exp_o     (exps),
        .sw_en_o   (sw_en),
        .run_o     (run)
    );

    for (genvar g = 0; g < N_OUT; g++) begin : g_out
        acd_out_gen #(.CNT_W(CNT_W), .EXP_W(EXP_W)) u_gen (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .cnt_i   (cnt),
            .exp_i   (exps[g]),
            .sw_en_i (sw_en[g]),
            .run_i   (run[g]),
            .clk_o   (clk_o[g]),
            .en_o    (en_o[g])
        );
    end

    // R5: when the slowest output rises, every running output is rising too
    a_r5_common_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
        en_o[OUT_DBG] |-> (en_o == clk_o));
endmodule

// File: tb/aligned_clk_divider_bench.sv
`timescale 1ns/1ps
module aligned_clk_divider_bench;
    logic       clk;
    logic       rst_n;
    logic       wr_en;
    logic       wr_addr;
    logic [3:0] wr_data;
    logic       grp_run;
    logic       busy;
    logic [3:0] clk_o;
    logic [3:0] en_o;

    int n_chk = 0;
    int n_bad = 0;

    // ratio table: select bits and expected periods of outputs 2 and 3
    localparam int NV = 4;
    localparam int V_BUS [NV] = '{0, 1, 0, 1};
    localparam int V_DBG [NV] = '{0, 0, 1, 1};
    localparam int V_BP  [NV] = '{2, 4, 2, 4};
    localparam int V_DP  [NV] = '{8, 8, 16, 16};

    aligned_clk_divider u_aligned_clk_divider (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .grp_run_i (grp_run),
        .busy_o    (busy),
        .clk_o     (clk_o),
        .en_o      (en_o)
    );

    initial begin
        clk = 1'b0;
        forever #2.5 clk = ~clk;
    end

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    // caller is at a negedge; returns at the next negedge
    task automatic wr(input logic addr, input logic [3:0] data);
        wr_en   = 1'b1;
        wr_addr = addr;
        wr_data = data;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 64; k++) begin
            if (!busy) break;
            @(negedge clk);
        end
    endtask

    task automatic measure(input int i, output int per, output int hi, output int ens);
        logic prev;
        bit   found;
        int   lo;
        per = 0; hi = 0; ens = 0; lo = 0; found = 0;
        prev = clk_o[i];
        for (int k = 0; k < 64; k++) begin
            @(negedge clk);
            if (!prev && clk_o[i]) begin found = 1; break; end
            prev = clk_o[i];
        end
        if (!found) return;
        hi  = 1;
        ens = en_o[i] ? 1 : 0;
        for (int k = 0; k < 64; k++) begin
            @(negedge clk);
            if (!clk_o[i]) break;
            hi++;
            if (en_o[i]) ens++;
        end
        lo = 1;
        if (en_o[i]) ens++;
        for (int k = 0; k < 64; k++) begin
            @(negedge clk);
            if (clk_o[i]) break;
            lo++;
            if (en_o[i]) ens++;
        end
        per = hi + lo;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int  per, hi, ens, cnt;
        logic [3:0] prev_v;
        bit  ok;
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = 1'b0; wr_data = '0; grp_run = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(clk_o == 4'h0, "R1 clk_o in reset", clk_o, 0);
        check(en_o == 4'h0, "R1 en_o in reset", en_o, 0);
        check(busy == 1'b0, "R1 busy in reset", busy, 0);
        rst_n = 1'b1;
        ok = 1;
        for (int k = 0; k < 15; k++) begin
            @(negedge clk);
            if (clk_o != 4'h0 || en_o != 4'h0) ok = 0;
        end
        check(ok, "R1 outputs low before first alignment", ok, 1);
        measure(2, per, hi, ens);
        check(per == 2, "R1 default bus ratio", per, 2);
        measure(3, per, hi, ens);
        check(per == 8, "R1 default debug ratio", per, 8);

        // table walk
        for (int v = 0; v < NV; v++) begin
            wr(1'b0, 4'(V_BUS[v] | (V_DBG[v] << 1)));
            check(busy == 1'b1, "R6 busy after ratio write", busy, 1);
            wait_idle();
            measure(0, per, hi, ens);
            check(per == 2, "R2 output 0 period", per, 2);
            check(hi == 1, "R8 output 0 high time", hi, 1);
            check(ens == 1, "R2 output 0 enables per period", ens, 1);
            measure(1, per, hi, ens);
            check(per == 4, "R2 output 1 period", per, 4);
            check(hi == 2, "R8 output 1 high time", hi, 2);
            check(ens == 1, "R2 output 1 enables per period", ens, 1);
            measure(2, per, hi, ens);
            check(per == V_BP[v], "R3 bus period", per, V_BP[v]);
            check(hi == V_BP[v] / 2, "R8 bus high time", hi, V_BP[v] / 2);
            check(ens == 1, "R3 bus enables per period", ens, 1);
            measure(3, per, hi, ens);
            check(per == V_DP[v], "R4 debug period", per, V_DP[v]);
            check(hi == V_DP[v] / 2, "R8 debug high time", hi, V_DP[v] / 2);
            check(ens == 1, "R4 debug enables per period", ens, 1);
            prev_v = clk_o;
            ok = 0;
            for (int k = 0; k < 40; k++) begin
                @(negedge clk);
                if (!prev_v[3] && clk_o[3]) begin
                    ok = (prev_v == 4'h0) && (clk_o == 4'hF);
                    break;
                end
                prev_v = clk_o;
            end
            check(ok, "R5 common rising edge", clk_o, 15);
        end

        // busy length and last-write-wins (state now bus=1, dbg=1)
        wr(1'b0, 4'h3);
        for (int k = 0; k < 40; k++) begin
            if (!busy) break;
            @(negedge clk);
        end
        // phase counter is zero here
        cnt = 0;
        wr(1'b0, 4'h2);
        if (busy) cnt++;
        @(negedge clk);
        if (busy) cnt++;
        wr(1'b0, 4'h0);
        if (busy) cnt++;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (!busy) break;
            cnt++;
        end
        check(cnt == 15, "R6 busy length to alignment", cnt, 15);
        measure(2, per, hi, ens);
        check(per == 2, "R6 last write wins bus", per, 2);
        measure(3, per, hi, ens);
        check(per == 8, "R6 last write wins debug", per, 8);

        // software gate on output 2
        wr(1'b1, 4'b1011);
        check(busy == 1'b0, "R7 gate write leaves busy low", busy, 0);
        repeat (20) @(negedge clk);
        ok = 1;
        for (int k = 0; k < 32; k++) begin
            @(negedge clk);
            if (clk_o[2] || en_o[2]) ok = 0;
        end
        check(ok, "R7 gated output held low", ok, 1);
        measure(0, per, hi, ens);
        check(per == 2, "R7 other output keeps running", per, 2);
        wr(1'b1, 4'b1111);
        measure(2, per, hi, ens);
        check(per == 2, "R7 output restarts after ungate", per, 2);
        check(hi == 1, "R8 restarted high time", hi, 1);

        // hardware group gate
        grp_run = 1'b0;
        repeat (20) @(negedge clk);
        ok = 1;
        for (int k = 0; k < 32; k++) begin
            @(negedge clk);
            if (clk_o != 4'h0 || en_o != 4'h0) ok = 0;
        end
        check(ok, "R9 group stopped low", ok, 1);
        grp_run = 1'b1;
        ok = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (clk_o != 4'h0) begin
                ok = (clk_o == 4'hF) && (en_o == 4'hF);
                break;
            end
        end
        check(ok, "R9 group restarts on common edge", clk_o, 15);
        measure(3, per, hi, ens);
        check(per == 8, "R9 debug ratio kept across stop", per, 8);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule